// File: doc/BRIEF.md
# Transmit completion status stack

This block sits between a transmit MAC and the host's register interface. Each frame that finishes transmission produces one completion event. The event carries error flags and the frame's request for an interrupt on success. The block keeps these events as records in a small first-in, first-out stack. It shows the oldest record to the host as one 8-bit status byte. A host write to the status port removes that record and exposes the next one.

The block also drives a transmit-complete interrupt cause. It tracks the errors after which the transmitter must stay off. Jabber and underrun completions, and a transmit FIFO overrun reported by the frame buffer, hold the transmitter disabled until a transmit reset command arrives. A FIFO overrun also raises a sticky adapter-failure flag. The asynchronous reset acts as the global reset.

Top module: `tx_status_stack`

## Requirements
- R1: When the stack holds a record, the status byte is {bit7 = 1 (complete), bit6 = interrupt-on-success requested, bit5 = jabber, bit4 = underrun, bit3 = maximum collisions, bit2 = records lost, bits 1..0 = 0}.
- R2: When the stack is empty, the status byte reads 0x00.
- R3: Records are presented oldest first. A pop shows the next-oldest record in the cycle after the pop.
- R4: A pop while the stack is empty has no effect.
- R5: The stack holds DEPTH records (default 4). A completion that arrives while the stack is full and no pop is taken is dropped. It sets bit 2 of the newest stored record.
- R6: A completion and a pop in the same cycle on a full stack are both taken. No record is lost and no overflow bit is set.
- R7: tx_cause_o is high while the head record has an error bit (5, 4, 3 or 2) or bit 6 set. A successful frame without an interrupt request leaves it low.
- R8: A completion with jabber or underrun sets tx_disable_o in the following cycle, even if the record is dropped. tx_disable_o stays set until a transmit reset.
- R9: A transmit FIFO overrun sets tx_disable_o and adapter_fail_o in the following cycle. Both stay set until a transmit reset.
- R10: A transmit reset empties the stack and clears the lockout and adapter failure in the following cycle. It takes priority over other inputs in the same cycle. A maximum-collisions error does not lock the transmitter.
- R11: After the asynchronous reset, the status byte is 0x00 and tx_cause_o, tx_disable_o and adapter_fail_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset (global reset) |
| done_valid_i | input | 1 | One-cycle completion event from the MAC |
| done_jabber_i | input | 1 | Completion ended with a jabber error |
| done_underrun_i | input | 1 | Completion ended with an underrun |
| done_maxcoll_i | input | 1 | Completion hit the collision limit |
| done_intreq_i | input | 1 | Frame requested an interrupt on success |
| pop_i | input | 1 | Host write to the status port |
| tx_reset_i | input | 1 | Transmit reset command |
| fifo_overrun_i | input | 1 | Transmit FIFO overrun from the frame buffer |
| status_o | output | 8 | Status byte of the oldest record |
| tx_cause_o | output | 1 | Transmit-complete interrupt cause |
| tx_disable_o | output | 1 | Transmitter locked off |
| adapter_fail_o | output | 1 | Adapter failure flag |

## Verification
The bench fills the stack beyond capacity. A design that overwrote the oldest record, or marked the wrong entry, would show the lost-record bit on the wrong byte or lose the oldest frame. It pops and pushes in the same cycle on a full stack, where an off-by-one full check would drop a frame or flag a false overflow. It also sends a jabber completion that is dropped, which must still lock the transmitter. Finally it pops an empty stack and resets a partly filled one, to catch pointer underflow and stale records that reappear after a transmit reset.

// File: rtl/tss_pkg.sv
package tss_pkg;
  typedef struct packed {
    logic ireq;
    logic jab;
    logic und;
    logic mc;
    logic ovf;
  } tss_rec_t;
endpackage

// File: rtl/tss_fifo.sv
module tss_fifo
  import tss_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     clr_i,
  input  logic     push_i,
  input  tss_rec_t rec_i,
  input  logic     pop_i,
  output tss_rec_t head_o,
  output logic     empty_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST_IDX = PW'(DEPTH - 1);

  logic [PW-1:0] rd_ptr_q, wr_ptr_q, newest;
  logic [CW-1:0] cnt_q;
  logic          full, do_pop, do_push, drop;
  tss_rec_t      ent [DEPTH];

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_pop  = pop_i && !empty_o;
  assign do_push = push_i && (!full || do_pop);
  assign drop    = push_i && full && !do_pop;
  assign newest  = (wr_ptr_q == '0) ? LAST_IDX : wr_ptr_q - 1'b1;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    tss_rec_t q;
    logic     wr_en, ovf_set;
    assign wr_en   = do_push && (wr_ptr_q == PW'(i));
    assign ovf_set = drop && (newest == PW'(i));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      q <= '0;
      else if (clr_i)   q <= '0;
      else if (wr_en)   q <= rec_i;
      else if (ovf_set) q.ovf <= 1'b1;
    end
    assign ent[i] = q;
  end

  assign head_o = ent[rd_ptr_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (clr_i) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_pop)  rd_ptr_q <= nxt(rd_ptr_q);
      if (do_push) wr_ptr_q <= nxt(wr_ptr_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assert_cnt_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  assert_pop_shrinks_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !empty_o && !push_i && !clr_i) |=> (cnt_q == $past(cnt_q) - 1'b1));
  assert_empty_pop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o && !push_i && !clr_i) |=> empty_o);
  assert_full_swap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full && push_i && pop_i && !clr_i) |=> (cnt_q == CW'(DEPTH)));
  assert_clr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> empty_o);
endmodule

// File: rtl/tss_lock.sv
module tss_lock (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic err_i,
  input  logic ovr_i,
  output logic lock_o,
  output logic fail_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_o <= 1'b0;
      fail_o <= 1'b0;
    end else if (clr_i) begin
      lock_o <= 1'b0;
      fail_o <= 1'b0;
    end else begin
      if (err_i || ovr_i) lock_o <= 1'b1;
      if (ovr_i)          fail_o <= 1'b1;
    end
  end

  assert_lock_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_i && !clr_i) |=> lock_o);
  assert_lock_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_o && !clr_i) |=> lock_o);
  assert_fail_set_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_i && !clr_i) |=> (fail_o && lock_o));
  assert_unlock_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!lock_o && !fail_o));
endmodule

// File: rtl/tss_fmt.sv
module tss_fmt
  import tss_pkg::*;
(
  input  tss_rec_t   head_i,
  input  logic       empty_i,
  output logic [7:0] status_o,
  output logic       cause_o
);
  always_comb begin
    if (empty_i) begin
      status_o = 8'h00;
      cause_o  = 1'b0;
    end else begin
      status_o = {1'b1, head_i.ireq, head_i.jab, head_i.und,
                  head_i.mc, head_i.ovf, 2'b00};
      cause_o  = head_i.ireq | head_i.jab | head_i.und | head_i.mc | head_i.ovf;
    end
  end
endmodule

// File: rtl/tx_status_stack.sv
module tx_status_stack
  import tss_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       done_valid_i,
  input  logic       done_jabber_i,
  input  logic       done_underrun_i,
  input  logic       done_maxcoll_i,
  input  logic       done_intreq_i,
  input  logic       pop_i,
  input  logic       tx_reset_i,
  input  logic       fifo_overrun_i,
  output logic [7:0] status_o,
  output logic       tx_cause_o,
  output logic       tx_disable_o,
  output logic       adapter_fail_o
);
  tss_rec_t rec, head;
  logic     empty, lock_err;

  assign rec = '{ireq: done_intreq_i, jab: done_jabber_i, und: done_underrun_i,
                 mc: done_maxcoll_i, ovf: 1'b0};
  assign lock_err = done_valid_i && (done_jabber_i || done_underrun_i);

  tss_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (tx_reset_i),
    .push_i (done_valid_i),
    .rec_i  (rec),
    .pop_i  (pop_i),
    .head_o (head),
    .empty_o(empty)
  );

  tss_lock u_lock (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (tx_reset_i),
    .err_i (lock_err),
    .ovr_i (fifo_overrun_i),
    .lock_o(tx_disable_o),
    .fail_o(adapter_fail_o)
  );

  tss_fmt u_fmt (
    .head_i  (head),
    .empty_i (empty),
    .status_o(status_o),
    .cause_o (tx_cause_o)
  );

  assert_empty_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty |-> (status_o == 8'h00 && !tx_cause_o));
  assert_layout_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !empty |-> (status_o[7] && status_o[1:0] == 2'b00));
  assert_push_visible_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_valid_i && !tx_reset_i) |=> status_o[7]);
  assert_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_cause_o |-> (status_o[6:2] != 5'b0));
endmodule

// File: tb/tx_status_stack_tb_top.sv
module tx_status_stack_tb_top;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ev = 0, jab = 0, und = 0, mc = 0, ireq = 0, pop = 0, trst = 0, ovr = 0;
  logic [7:0] status;
  logic       cause, dis, fail;
  int         total = 0, bad = 0;
  bit         done = 0;

  always #2 clk = ~clk;

  tx_status_stack #(.DEPTH(4)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .done_valid_i(ev), .done_jabber_i(jab),
    .done_underrun_i(und), .done_maxcoll_i(mc), .done_intreq_i(ireq),
    .pop_i(pop), .tx_reset_i(trst), .fifo_overrun_i(ovr),
    .status_o(status), .tx_cause_o(cause), .tx_disable_o(dis),
    .adapter_fail_o(fail)
  );

  // {ev,jab,und,mc,ireq,pop,trst,ovr, status, cause, dis, fail}
  localparam int NV = 14;
  localparam logic [18:0] VEC [NV] = '{
    {8'b1000_0000, 8'h80, 3'b000},  // plain success, silent
    {8'b0000_0100, 8'h00, 3'b000},  // pop -> empty
    {8'b1000_1000, 8'hC0, 3'b100},  // interrupt requested
    {8'b1001_0000, 8'hC0, 3'b100},  // maxcoll behind it
    {8'b0000_0100, 8'h88, 3'b100},  // next record, no lock
    {8'b0000_0100, 8'h00, 3'b000},
    {8'b0000_0100, 8'h00, 3'b000},  // pop on empty
    {8'b1100_0000, 8'hA0, 3'b110},  // jabber locks
    {8'b0000_0100, 8'h00, 3'b010},  // lock survives pop
    {8'b0000_0010, 8'h00, 3'b000},  // tx reset unlocks
    {8'b1010_0000, 8'h90, 3'b110},  // underrun locks
    {8'b0000_0010, 8'h00, 3'b000},
    {8'b0000_0001, 8'h00, 3'b011},  // fifo overrun
    {8'b0000_0010, 8'h00, 3'b000}
  };

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [7:0] c);
    @(negedge clk);
    {ev, jab, und, mc, ireq, pop, trst, ovr} = c;
    @(negedge clk);
    {ev, jab, und, mc, ireq, pop, trst, ovr} = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #400000;
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    #7 rst_ni = 1'b1;
    @(negedge clk);
    chk("R11 status", status, 8'h00);
    chk("R11 flags", {cause, dis, fail}, 3'b000);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][18:11]);
      chk("R1 R3 R4 status", status, VEC[i][10:3]);
      chk("R7 cause", cause, VEC[i][2]);
      chk("R8 R10 disable", dis, VEC[i][1]);
      chk("R9 fail", fail, VEC[i][0]);
    end

    // R5: overflow, dropped jabber still locks
    drive(8'b1000_1000);
    drive(8'b1001_0000);
    drive(8'b1000_0000);
    drive(8'b1000_1000);
    chk("R5 no lock yet", dis, 0);
    drive(8'b1100_0000);
    chk("R5 head kept", status, 8'hC0);
    chk("R8 dropped jabber locks", dis, 1);
    drive(8'b0000_0100); chk("R5 second", status, 8'h88);
    drive(8'b0000_0100); chk("R5 third", status, 8'h80);
    drive(8'b0000_0100); chk("R5 newest marked", status, 8'hC4);
    chk("R7 cause on lost", cause, 1);
    drive(8'b0000_0100); chk("R2 empty", status, 8'h00);
    drive(8'b0000_0100); chk("R4 pop empty", status, 8'h00);
    drive(8'b0000_0010); chk("R10 unlock", dis, 0);

    // R6: push and pop together on a full stack
    for (int k = 0; k < 4; k++) drive(8'b1000_0000);
    drive(8'b1001_0100);
    chk("R6 head", status, 8'h80);
    drive(8'b0000_0100); chk("R6 second", status, 8'h80);
    drive(8'b0000_0100); chk("R6 third", status, 8'h80);
    drive(8'b0000_0100); chk("R6 pushed, no ovf", status, 8'h88);
    drive(8'b0000_0100); chk("R6 empty", status, 8'h00);

    // R10: reset priority over a simultaneous event
    drive(8'b1000_1000);
    drive(8'b1000_0000);
    drive(8'b1100_0010);
    chk("R10 cleared", status, 8'h00);
    chk("R10 no lock", dis, 0);
    drive(8'b0000_0100); chk("R10 no stale record", status, 8'h00);

    // R11: asynchronous reset mid-run
    drive(8'b1100_1001);
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    chk("R11 async status", status, 8'h00);
    chk("R11 async flags", {cause, dis, fail}, 3'b000);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R11 after release", status, 8'h00);

    finish_run();
  end
endmodule